// File: doc/BRIEF.md
# UART Host-Side Data and Status Port

This block sits between a processor bus and the serial core of a UART. One data address serves two buffers: a write places a character in a single transmit holding register, and a read takes the oldest character out of a two-entry receive queue. A second address holds an 8-bit status word with the receive-ready, transmit-done and holding-register-empty flags, three per-character error bits, and two mode bits that software can write.

On the core side, the block offers a held character to the transmit shifter through a combinational load strobe. The strobe fires when transmission is enabled and the shifter reports it is idle. Received characters arrive with a one-cycle valid strobe and their framing and parity error flags. A two-bit size code trims characters to 5, 6, 7 or 8 bits in both directions. Three interrupt request outputs gate the flags with per-flag enable inputs.

Top module: `uart_host_port`

## Requirements
- R1: A data-address write while the empty flag (status bit 5) is 1 fills the holding register, and bit 5 reads 0 from the next cycle on. `tx_load` is high in a cycle exactly when the register is full, `tx_en` is 1 and `tx_shift_empty` is 1. In that cycle `tx_byte` carries the character, and bit 5 reads 1 again from the next cycle.
- R2: A data-address write while status bit 5 is 0 is dropped: the character later presented on `tx_byte` is the earlier one.
- R3: Size code `char_size` 0, 1, 2, 3 selects 5, 6, 7, 8 bits. Bits at or above the chosen width of a written character are zero on `tx_byte`.
- R4: The receive queue holds two characters. Each data-address read returns the oldest character and removes it. A read of an empty queue returns 0x00 and changes nothing.
- R5: Bits at or above the chosen width of a received character read back as zero.
- R6: Status bit 7 (receive-ready) is 1 exactly when the queue holds at least one unread character.
- R7: While `rx_en` is 0 the queue is emptied and arriving characters are discarded. Status bit 7 reads 0.
- R8: A character that arrives while the queue is full, with no read in the same cycle, is dropped. The overrun bit (status bit 3) is then set on the newest stored character and becomes visible when that character reaches the head.
- R9: The frame-error bit (status bit 4) and parity-error bit (status bit 2) are stored with each character. They show the values of the character at the head, and read 0 when the queue is empty.
- R10: Transmit-done (status bit 6) sets on a `tx_frame_done` pulse while the holding register is empty, and stays clear if a character is waiting. It clears on `txc_ack` or on a status write with bit 6 = 1. A status write with bit 6 = 0 leaves it unchanged, and a set in the same cycle as a clear wins.
- R11: The status word resets to 0x20. Status writes store bit 1 and bit 0, which appear on `dbl_speed` and `mp_mode`. Bits 7, 5, 4, 3 and 2 ignore writes.
- R12: `irq_rxc`, `irq_txc` and `irq_dre` equal status bits 7, 6 and 5, each ANDed with its enable input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Address: 0 data, 1 status |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (pops the queue on the data address) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected address |
| char_size | input | 2 | Character size code (0..3 = 5..8 bits) |
| tx_en | input | 1 | Transmitter enable |
| rx_en | input | 1 | Receiver enable |
| tx_shift_empty | input | 1 | Transmit shifter idle and able to take a character |
| tx_load | output | 1 | Hand the held character to the shifter |
| tx_byte | output | 8 | Character handed to the shifter |
| tx_frame_done | input | 1 | Pulse: last frame bit has left the shifter |
| rx_valid | input | 1 | Pulse: received character available |
| rx_byte | input | 8 | Received character |
| rx_frame_err | input | 1 | Frame error of the received character |
| rx_parity_err | input | 1 | Parity error of the received character |
| ie_rxc | input | 1 | Receive-ready interrupt enable |
| ie_txc | input | 1 | Transmit-done interrupt enable |
| ie_dre | input | 1 | Holding-empty interrupt enable |
| txc_ack | input | 1 | Transmit-done interrupt taken |
| dbl_speed | output | 1 | Stored status bit 1 |
| mp_mode | output | 1 | Stored status bit 0 |
| irq_rxc | output | 1 | Receive-ready request |
| irq_txc | output | 1 | Transmit-done request |
| irq_dre | output | 1 | Holding-empty request |

## Verification
Transmit is exercised three ways:
- a full-width character, which confirms the hand-off;
- a write onto an occupied holding register, which shows the drop;
- an all-ones character at 5-bit size, which separates trimming from pass-through.

Receive is filled to two entries and then offered a third character. Each entry carries a different error flag, so in-order popping, the per-entry error bits and the overrun marking each produce distinct status values. Further patterns cover transmit-done with the holding register empty versus full, each of its clear paths, and a flush while the receiver is disabled. The flush pattern tells emptying apart from merely ignoring new arrivals.

// File: rtl/uhp_pkg.sv
package uhp_pkg;
    localparam int CHAR_W = 8;

    localparam int ST_RXC = 7;
    localparam int ST_TXC = 6;
    localparam int ST_DRE = 5;
    localparam int ST_FE  = 4;
    localparam int ST_DOR = 3;
    localparam int ST_PE  = 2;
    localparam int ST_DBL = 1;
    localparam int ST_MPM = 0;

    typedef struct packed {
        logic [CHAR_W-1:0] data;
        logic              fe;
        logic              pe;
        logic              dor;
    } rx_entry_t;

    // Keep only the low 5..8 bits selected by the size code.
    function automatic logic [CHAR_W-1:0] char_mask(input logic [1:0] sz);
        return {CHAR_W{1'b1}} >> (2'd3 - sz);
    endfunction
endpackage

// File: rtl/uhp_tx_hold.sv
module uhp_tx_hold
    import uhp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_req,
    input  logic [CHAR_W-1:0] wdata,
    input  logic [1:0]        char_size,
    input  logic              tx_en,
    input  logic              shift_empty,
    output logic              load,
    output logic [CHAR_W-1:0] load_data,
    output logic              hold_empty
);
    typedef struct packed {
        logic              full;
        logic [CHAR_W-1:0] data;
    } hold_t;

    hold_t hold_d, hold_q;

    always_comb begin
        hold_d = hold_q;
        load   = hold_q.full & tx_en & shift_empty;
        if (load) begin
            hold_d.full = 1'b0;
        end else if (wr_req && !hold_q.full) begin
            hold_d.full = 1'b1;
            hold_d.data = wdata & char_mask(char_size);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hold_q <= '0;
        else        hold_q <= hold_d;
    end

    assign load_data  = hold_q.data;
    assign hold_empty = ~hold_q.full;

    // R1: an accepted write leaves the register occupied
    a_r1_write_fills: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && hold_empty) |=> !hold_empty);
    // R1: a hand-off frees the register
    a_r1_load_frees: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> hold_empty);
    // R2: a write onto a full register keeps the held character
    a_r2_full_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && !hold_empty) |=> $stable(load_data));
    // R3: bits above the chosen width are zero after a write
    a_r3_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && hold_empty) |=> ((load_data & ~char_mask($past(char_size))) == '0));
endmodule

// File: rtl/uhp_rx_fifo.sv
module uhp_rx_fifo
    import uhp_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              push,
    input  logic [CHAR_W-1:0] push_data,
    input  logic              push_fe,
    input  logic              push_pe,
    input  logic [1:0]        char_size,
    input  logic              pop,
    output rx_entry_t         head,
    output logic              not_empty
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        rx_entry_t [DEPTH-1:0] mem;
        logic [PTR_W-1:0]      rd_ptr;
        logic [PTR_W-1:0]      wr_ptr;
        logic [CNT_W-1:0]      count;
    } fifo_t;

    fifo_t f_d, f_q;
    logic  do_pop, do_push, overrun;

    always_comb begin
        f_d     = f_q;
        do_pop  = 1'b0;
        do_push = 1'b0;
        overrun = 1'b0;
        if (!enable) begin
            f_d.rd_ptr = '0;
            f_d.wr_ptr = '0;
            f_d.count  = '0;
        end else begin
            do_pop  = pop && (f_q.count != '0);
            do_push = push && ((f_q.count != CNT_W'(DEPTH)) || do_pop);
            overrun = push && (f_q.count == CNT_W'(DEPTH)) && !do_pop;
            if (do_pop) begin
                f_d.rd_ptr = f_q.rd_ptr + PTR_W'(1);
            end
            if (do_push) begin
                f_d.mem[f_q.wr_ptr] = '{data: push_data & char_mask(char_size),
                                        fe: push_fe, pe: push_pe, dor: 1'b0};
                f_d.wr_ptr = f_q.wr_ptr + PTR_W'(1);
            end
            if (overrun) begin
                f_d.mem[f_q.wr_ptr - PTR_W'(1)].dor = 1'b1;
            end
            f_d.count = f_q.count + CNT_W'(do_push) - CNT_W'(do_pop);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    assign not_empty = (f_q.count != '0);
    assign head      = not_empty ? f_q.mem[f_q.rd_ptr] : '0;

    // R7: a disabled receiver leaves the queue empty
    a_r7_flush: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !not_empty);
    // R4: the occupancy never exceeds the depth
    a_r4_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        f_q.count <= CNT_W'(DEPTH));
    // R4: a pop alone lowers the occupancy by one
    a_r4_pop_dec: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && pop && not_empty && !push) |=> (f_q.count == $past(f_q.count) - CNT_W'(1)));
    // R8: a dropped arrival marks the newest stored entry and keeps the queue full
    a_r8_overrun_mark: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && push && !pop && f_q.count == CNT_W'(DEPTH))
        |=> (f_q.count == CNT_W'(DEPTH)) && f_q.mem[f_q.wr_ptr - PTR_W'(1)].dor);
endmodule

// File: rtl/uhp_status.sv
module uhp_status
    import uhp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stat_wr,
    input  logic [CHAR_W-1:0] wdata,
    input  logic              frame_done,
    input  logic              hold_empty,
    input  logic              txc_ack,
    output logic              txc,
    output logic              dbl,
    output logic              mpm
);
    typedef struct packed {
        logic txc;
        logic dbl;
        logic mpm;
    } stat_t;

    stat_t s_d, s_q;
    logic  unused_wbits;

    assign unused_wbits = ^{wdata[7], wdata[5:2]};

    always_comb begin
        s_d = s_q;
        if (frame_done && hold_empty) begin
            s_d.txc = 1'b1;
        end else if (txc_ack || (stat_wr && wdata[ST_TXC])) begin
            s_d.txc = 1'b0;
        end
        if (stat_wr) begin
            s_d.dbl = wdata[ST_DBL];
            s_d.mpm = wdata[ST_MPM];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign txc = s_q.txc;
    assign dbl = s_q.dbl;
    assign mpm = s_q.mpm;

    // R10: end of frame with nothing waiting raises transmit-done
    a_r10_txc_set: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && hold_empty) |=> txc);
    // R10: acknowledge or write-one clears when no set competes
    a_r10_txc_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (!(frame_done && hold_empty) && (txc_ack || (stat_wr && wdata[ST_TXC]))) |=> !txc);
    // R10: no rise without a completed frame
    a_r10_txc_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(txc) |-> $past(frame_done && hold_empty));
    // R11: mode bits hold between status writes
    a_r11_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_wr |=> ($stable(dbl) && $stable(mpm)));
endmodule

// File: rtl/uart_host_port.sv
module uart_host_port
    import uhp_pkg::*;
#(
    parameter int RX_DEPTH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [CHAR_W-1:0] bus_wdata,
    output logic [CHAR_W-1:0] bus_rdata,
    input  logic [1:0]        char_size,
    input  logic              tx_en,
    input  logic              rx_en,
    input  logic              tx_shift_empty,
    output logic              tx_load,
    output logic [CHAR_W-1:0] tx_byte,
    input  logic              tx_frame_done,
    input  logic              rx_valid,
    input  logic [CHAR_W-1:0] rx_byte,
    input  logic              rx_frame_err,
    input  logic              rx_parity_err,
    input  logic              ie_rxc,
    input  logic              ie_txc,
    input  logic              ie_dre,
    input  logic              txc_ack,
    output logic              dbl_speed,
    output logic              mp_mode,
    output logic              irq_rxc,
    output logic              irq_txc,
    output logic              irq_dre
);
    logic              data_wr, data_rd, stat_wr;
    logic              hold_empty, rx_ready, txc;
    rx_entry_t         rx_head;
    logic [CHAR_W-1:0] status;

    assign data_wr = bus_wr & ~bus_sel;
    assign data_rd = bus_rd & ~bus_sel;
    assign stat_wr = bus_wr &  bus_sel;

    uhp_tx_hold u_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_req     (data_wr),
        .wdata      (bus_wdata),
        .char_size  (char_size),
        .tx_en      (tx_en),
        .shift_empty(tx_shift_empty),
        .load       (tx_load),
        .load_data  (tx_byte),
        .hold_empty (hold_empty)
    );

    uhp_rx_fifo #(.DEPTH(RX_DEPTH)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (rx_en),
        .push      (rx_valid),
        .push_data (rx_byte),
        .push_fe   (rx_frame_err),
        .push_pe   (rx_parity_err),
        .char_size (char_size),
        .pop       (data_rd),
        .head      (rx_head),
        .not_empty (rx_ready)
    );

    uhp_status u_st (
        .clk       (clk),
        .rst_n     (rst_n),
        .stat_wr   (stat_wr),
        .wdata     (bus_wdata),
        .frame_done(tx_frame_done),
        .hold_empty(hold_empty),
        .txc_ack   (txc_ack),
        .txc       (txc),
        .dbl       (dbl_speed),
        .mpm       (mp_mode)
    );

    always_comb begin
        status         = '0;
        status[ST_RXC] = rx_ready;
        status[ST_TXC] = txc;
        status[ST_DRE] = hold_empty;
        status[ST_FE]  = rx_head.fe;
        status[ST_DOR] = rx_head.dor;
        status[ST_PE]  = rx_head.pe;
        status[ST_DBL] = dbl_speed;
        status[ST_MPM] = mp_mode;
    end

    assign bus_rdata = bus_sel ? status : rx_head.data;

    assign irq_rxc = rx_ready   & ie_rxc;
    assign irq_txc = txc        & ie_txc;
    assign irq_dre = hold_empty & ie_dre;

    // R6: an accepted arrival makes receive-ready visible
    a_r6_arrival_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_en && rx_valid) |=> rx_ready);
    // R9: error bits read zero with an empty queue
    a_r9_empty_no_err: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_ready |-> (status[ST_FE:ST_PE] == 3'b000));
    // R1: a hand-off and an accepted write never coincide
    a_r1_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_load && hold_empty));
endmodule

// File: tb/sim_uart_host_port.sv
module sim_uart_host_port;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_sel = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [1:0] char_size = 2'd3;
    logic       tx_en = 1'b0, rx_en = 1'b0, tx_shift_empty = 1'b0;
    logic       tx_load;
    logic [7:0] tx_byte;
    logic       tx_frame_done = 1'b0, rx_valid = 1'b0;
    logic [7:0] rx_byte = '0;
    logic       rx_frame_err = 1'b0, rx_parity_err = 1'b0;
    logic       ie_rxc = 1'b0, ie_txc = 1'b0, ie_dre = 1'b0, txc_ack = 1'b0;
    logic       dbl_speed, mp_mode, irq_rxc, irq_txc, irq_dre;

    int   n_vec = 0;
    int   n_bad = 0;
    bit   done = 1'b0;
    logic [7:0] exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_host_port u0 (.*);

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic sel, input logic [7:0] d);
        @(negedge clk);
        bus_sel = sel; bus_wr = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic sel, output logic [7:0] d);
        @(negedge clk);
        bus_sel = sel; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic peek_status(output logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1;
        #1 d = bus_rdata;
    endtask

    // Driver: write a character and record the trimmed value expected on the shifter side
    task automatic send(input logic [7:0] d);
        exp_q.push_back(d & (8'hFF >> (2'd3 - char_size)));
        wr(1'b0, d);
    endtask

    task automatic handoff;
        @(negedge clk);
        tx_en = 1'b1; tx_shift_empty = 1'b1;
        @(negedge clk);
        tx_shift_empty = 1'b0;
    endtask

    task automatic rx_push(input logic [7:0] d, input logic fe, input logic pe);
        @(negedge clk);
        rx_valid = 1'b1; rx_byte = d; rx_frame_err = fe; rx_parity_err = pe;
        @(negedge clk);
        rx_valid = 1'b0; rx_frame_err = 1'b0; rx_parity_err = 1'b0;
    endtask

    task automatic pulse_done;
        @(negedge clk);
        tx_frame_done = 1'b1;
        @(negedge clk);
        tx_frame_done = 1'b0;
    endtask

    // Monitor: every hand-off must match the oldest expected character (R1, R2, R3)
    always @(negedge clk) begin
        #3;
        if (rst_n && tx_load) begin
            if (exp_q.size() == 0) begin
                check("R1 unexpected tx_load", tx_byte, 8'hxx);
            end else begin
                check("R1/R2/R3 tx_byte", tx_byte, exp_q.pop_front());
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_bad++;
            n_vec++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R11: reset value
        peek_status(v); check("R11 reset status", v, 8'h20);
        check("R12 irqs at reset", {5'b0, irq_rxc, irq_txc, irq_dre}, 8'h00);
        ie_dre = 1'b1; #1;
        check("R12 irq_dre with enable", {7'b0, irq_dre}, 8'h01);

        // R1 / R2: full-width write, then a dropped write
        char_size = 2'd3;
        send(8'hA5);
        peek_status(v); check("R1 empty flag clears", v & 8'h20, 8'h00);
        check("R12 irq_dre follows flag", {7'b0, irq_dre}, 8'h00);
        wr(1'b0, 8'h3C);
        handoff;
        peek_status(v); check("R1 empty flag returns", v & 8'h20, 8'h20);

        // R3: 5-bit trimming on transmit
        char_size = 2'd0;
        send(8'hFF);
        handoff;
        char_size = 2'd3;

        // R10: transmit-done set and clear paths
        ie_txc = 1'b1;
        pulse_done;
        peek_status(v); check("R10 txc sets", v & 8'h40, 8'h40);
        check("R12 irq_txc", {7'b0, irq_txc}, 8'h01);
        wr(1'b1, 8'h00);
        peek_status(v); check("R10 write zero keeps txc", v & 8'h40, 8'h40);
        wr(1'b1, 8'h40);
        peek_status(v); check("R10 write one clears txc", v & 8'h40, 8'h00);
        pulse_done;
        @(negedge clk); txc_ack = 1'b1; @(negedge clk); txc_ack = 1'b0;
        peek_status(v); check("R10 ack clears txc", v & 8'h40, 8'h00);
        tx_en = 1'b0;
        send(8'h5A);
        pulse_done;
        peek_status(v); check("R10 no set while waiting", v & 8'h40, 8'h00);
        handoff;

        // R11: mode bits writable, read-only bits ignore writes
        wr(1'b1, 8'hBF);
        peek_status(v); check("R11 status after write", v, 8'h23);
        check("R11 mode ports", {6'b0, dbl_speed, mp_mode}, 8'h03);
        wr(1'b1, 8'h00);

        // R4 / R6 / R8 / R9: fill the queue and overrun it
        rx_en = 1'b1; ie_rxc = 1'b1;
        peek_status(v); check("R6 empty queue", v & 8'h80, 8'h00);
        rx_push(8'h11, 1'b1, 1'b0);
        rx_push(8'h22, 1'b0, 1'b1);
        rx_push(8'h33, 1'b0, 1'b0);
        peek_status(v); check("R9 head errors fe", v & 8'h9C, 8'h90);
        check("R12 irq_rxc", {7'b0, irq_rxc}, 8'h01);
        rd(1'b0, v); check("R4 first pop", v, 8'h11);
        peek_status(v); check("R8/R9 second head pe+dor", v & 8'h9C, 8'h8C);
        rd(1'b0, v); check("R4/R8 second pop, third dropped", v, 8'h22);
        peek_status(v); check("R6 ready clears", v & 8'h9C, 8'h00);
        rd(1'b0, v); check("R4 empty read", v, 8'h00);

        // R5: receive trimming at 6 bits
        char_size = 2'd1;
        rx_push(8'hFF, 1'b0, 1'b0);
        rd(1'b0, v); check("R5 trimmed receive", v, 8'h3F);
        char_size = 2'd3;

        // R7: flush and discard while disabled
        rx_push(8'h44, 1'b0, 1'b0);
        rx_push(8'h55, 1'b0, 1'b0);
        @(negedge clk); rx_en = 1'b0;
        rx_push(8'h66, 1'b0, 1'b0);
        @(negedge clk); rx_en = 1'b1;
        peek_status(v); check("R7 flushed", v & 8'h80, 8'h00);
        rd(1'b0, v); check("R7 nothing kept", v, 8'h00);

        repeat (3) @(negedge clk);
        check("R1 all hand-offs seen", 8'(exp_q.size()), 8'h00);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule